// File: doc/BRIEF.md
# Port Pin Change Monitor

This block is an 8-bit bidirectional port with an input-change detector on its upper four pins. It holds an output data latch and a direction register, and it returns the synchronised pin levels on a read data path. Each time the processor reads the port, the block copies the synchronised upper-nibble pin levels into a snapshot register. From then on, every upper pin that is an input is compared with its snapshot. Any difference sets one sticky change flag, which stays set until software clears it. The flag is ANDed with an enable bit to form the interrupt request.

Software arms the detector by reading the port. The reference for the comparison is therefore the value seen at the last read, not the pin level on the previous clock. A typical handler reads the port and clears the flag in the same cycle. The flag then stays clear until a pin moves away from what the handler saw. All register accesses are single-cycle strobes that are always accepted. No valid/ready handshake exists and nothing is ever held back.

Top module: `port_ioc`

## Requirements
- R1: While reset is asserted and after it is released, the data latch reads 0x00 and every direction bit is 1 (input), so `pin_oe` is 0x00. The change flag, the enable and `irq` are 0.
- R2: A `lat_wr` strobe loads `wr_data` into the data latch, and `pin_o` shows it after the next rising edge. A `dir_wr` strobe loads `wr_data` into the direction register, where bit value 1 means input and 0 means output. After the next rising edge `pin_oe` equals the bitwise inverse of that value.
- R3: `rd_data` shows the pin levels through a two-flop synchroniser. A pin change appears on `rd_data` after the second rising edge and not after the first.
- R4: An `rd_port` strobe captures bits [7:4] of the synchronised pins into the snapshot. When a synchronised upper input pin differs from its snapshot bit, the change flag is set at the next rising edge, which is the third edge after the pin changes.
- R5: Changes on pins [3:0] never set the change flag.
- R6: An upper pin whose direction bit is 0 takes no part in the comparison. When that bit returns to 1, any difference against the snapshot sets the flag.
- R7: The flag is sticky: it stays set when the pins return to the snapshot value.
- R8: A `flag_clr` strobe clears the flag at the next edge. If a difference still exists, the flag is set again at the edge after that.
- R9: `irq` is high exactly when both the flag and the enable bit are set. The enable bit is written through `en_wr`/`en_data`, and the flag sets whether or not the enable is set.
- R10: Writing the data latch does not change the snapshot.
- R11: A read combined with a clear re-arms the detector: with the pins held steady afterwards, the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Output data latch to the pads |
| pin_oe | output | 8 | Pad drive enable, 1 = drive |
| lat_wr | input | 1 | Write strobe for the data latch |
| dir_wr | input | 1 | Write strobe for the direction register |
| wr_data | input | 8 | Write data for latch or direction |
| rd_port | input | 1 | Port read strobe; refreshes the snapshot |
| rd_data | output | 8 | Synchronised pin levels |
| en_wr | input | 1 | Write strobe for the interrupt enable |
| en_data | input | 1 | New interrupt enable value |
| flag_clr | input | 1 | Clear strobe for the change flag |
| chg_flag | output | 1 | Sticky change flag |
| irq | output | 1 | Interrupt request |

## Verification
Each result arrives after a fixed number of edges. A latch, direction or enable write shows at the next edge. A pin change reaches `rd_data` after two edges and the change flag after three. A clear takes effect at the next edge, and a persisting difference sets the flag again one edge after that. The bench changes inputs just after a falling edge and samples 1 ns after the rising edge that the requirement names, so the timing checks see the value both before and at the due edge. The table steps wait four edges before they sample and then re-arm the detector, so each step compares its pins only against the previous step.

// File: rtl/port_ioc_pkg.sv
package port_ioc_pkg;
  localparam int unsigned PORT_W_DEF = 8;
  localparam int unsigned MON_LO_DEF = 4;
  localparam int unsigned SYNC_N_DEF = 2;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } dir_e;
endpackage

// File: rtl/port_ioc_sync.sv
module port_ioc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/port_ioc_regs.sv
module port_ioc_regs
  import port_ioc_pkg::*;
#(
  parameter int unsigned W = PORT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_wr,
  input  logic         dir_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= {W{DIR_IN}};
    end else begin
      if (lat_wr) lat_q <= wr_data;
      if (dir_wr) dir_q <= wr_data;
    end
  end
endmodule

// File: rtl/port_ioc_detect.sv
module port_ioc_detect
  import port_ioc_pkg::*;
#(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] pin_s,
  input  logic [MW-1:0] dir_m,
  input  logic          rd_port,
  input  logic          flag_clr,
  input  logic          en_wr,
  input  logic          en_data,
  output logic          flag,
  output logic          irq
);
  logic [MW-1:0] snap_q;
  logic [MW-1:0] diff;
  logic          en_q;
  logic          any_diff;

  for (genvar g = 0; g < int'(MW); g++) begin : g_cmp
    assign diff[g] = (pin_s[g] ^ snap_q[g]) & (dir_m[g] == DIR_IN);
  end

  assign any_diff = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (rd_port) snap_q <= pin_s;
      if (en_wr)   en_q   <= en_data;
      if (flag_clr)      flag <= 1'b0;
      else if (any_diff) flag <= 1'b1;
    end
  end

  assign irq = flag & en_q;
endmodule

// File: rtl/port_ioc.sv
module port_ioc
  import port_ioc_pkg::*;
#(
  parameter int unsigned PORT_W = PORT_W_DEF,
  parameter int unsigned MON_LO = MON_LO_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe,
  input  logic              lat_wr,
  input  logic              dir_wr,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_port,
  output logic [PORT_W-1:0] rd_data,
  input  logic              en_wr,
  input  logic              en_data,
  input  logic              flag_clr,
  output logic              chg_flag,
  output logic              irq
);
  localparam int unsigned MW = PORT_W - MON_LO;

  logic [PORT_W-1:0] pin_s;
  logic [PORT_W-1:0] lat_q;
  logic [PORT_W-1:0] dir_q;

  port_ioc_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  port_ioc_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .dir_wr(dir_wr),
    .wr_data(wr_data), .lat_q(lat_q), .dir_q(dir_q)
  );

  port_ioc_detect #(.MW(MW)) u_det (
    .clk(clk), .rst_n(rst_n),
    .pin_s(pin_s[PORT_W-1:MON_LO]), .dir_m(dir_q[PORT_W-1:MON_LO]),
    .rd_port(rd_port), .flag_clr(flag_clr),
    .en_wr(en_wr), .en_data(en_data),
    .flag(chg_flag), .irq(irq)
  );

  assign pin_o   = lat_q;
  assign pin_oe  = ~dir_q;
  assign rd_data = pin_s;
endmodule

// File: rtl/port_ioc_chk.sv
module port_ioc_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lat_wr,
  input logic         dir_wr,
  input logic [W-1:0] wr_data,
  input logic         flag_clr,
  input logic         en_wr,
  input logic         en_data,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oe,
  input logic         chg_flag,
  input logic         irq
);
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  assert_reset_state_R1: assert property (@(posedge clk)
    (seen_edge && !rst_n) |-> (!chg_flag && !irq && pin_oe == '0 && pin_o == '0));

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> (pin_o == $past(wr_data)));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pin_oe == ~$past(wr_data)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !flag_clr) |=> chg_flag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !chg_flag);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_data) |=> !irq);
endmodule

bind port_ioc port_ioc_chk #(.W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .dir_wr(dir_wr),
  .wr_data(wr_data), .flag_clr(flag_clr), .en_wr(en_wr), .en_data(en_data),
  .pin_o(pin_o), .pin_oe(pin_oe), .chg_flag(chg_flag), .irq(irq)
);

// File: tb/port_ioc_bench.sv
`timescale 1ns/1ps
module port_ioc_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_i, pin_o, pin_oe, wr_data, rd_data;
  logic       lat_wr, dir_wr, rd_port, en_wr, en_data, flag_clr;
  logic       chg_flag, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  port_ioc u_port_ioc (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .lat_wr(lat_wr), .dir_wr(dir_wr), .wr_data(wr_data), .rd_port(rd_port),
    .rd_data(rd_data), .en_wr(en_wr), .en_data(en_data), .flag_clr(flag_clr),
    .chg_flag(chg_flag), .irq(irq)
  );

  // {pins[7:0], expected flag}; all pins are inputs, enable is on
  localparam logic [8:0] VEC [10] = '{
    {8'h00, 1'b0}, {8'h0F, 1'b0}, {8'h1F, 1'b1}, {8'h1F, 1'b0}, {8'hA5, 1'b1},
    {8'hA3, 1'b0}, {8'h53, 1'b1}, {8'h5C, 1'b0}, {8'hFF, 1'b1}, {8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic read_clear();
    @(negedge clk); rd_port = 1'b1; flag_clr = 1'b1;
    @(negedge clk); rd_port = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; pin_i = 8'h00; lat_wr = 0; dir_wr = 0; wr_data = 0;
    rd_port = 0; en_wr = 0; en_data = 0; flag_clr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe in reset", pin_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    wait_edges(1);
    chk("R1 latch", pin_o, 8'h00);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 flag", {7'd0, chg_flag}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    @(negedge clk); en_wr = 1; en_data = 1;
    @(negedge clk); en_wr = 0;

    // table walk: R4, R5, R9, R3, R11
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); pin_i = VEC[i][8:1];
      wait_edges(4);
      chk("R4/R5 flag", {7'd0, chg_flag}, {7'd0, VEC[i][0]});
      chk("R9 irq", {7'd0, irq}, {7'd0, VEC[i][0]});
      chk("R3 rd_data", rd_data, VEC[i][8:1]);
      read_clear();
      wait_edges(2);
      chk("R11 rearmed", {7'd0, chg_flag}, 8'h00);
    end

    // R3 / R4 edge timing; snapshot holds 0x0 for the upper pins
    @(negedge clk); pin_i = 8'h21;
    wait_edges(1);
    chk("R3 after 1 edge", rd_data, 8'h00);
    wait_edges(1);
    chk("R3 after 2 edges", rd_data, 8'h21);
    chk("R4 flag not yet", {7'd0, chg_flag}, 8'h00);
    wait_edges(1);
    chk("R4 flag at edge 3", {7'd0, chg_flag}, 8'h01);

    // R7: return to the snapshot value, flag stays
    @(negedge clk); pin_i = 8'h01;
    wait_edges(4);
    chk("R7 sticky", {7'd0, chg_flag}, 8'h01);
    read_clear();

    // R8: clear with a persisting difference
    @(negedge clk); pin_i = 8'h81;
    wait_edges(4);
    chk("R8 set", {7'd0, chg_flag}, 8'h01);
    @(negedge clk); flag_clr = 1;
    wait_edges(1);
    chk("R8 cleared", {7'd0, chg_flag}, 8'h00);
    @(negedge clk); flag_clr = 0;
    wait_edges(1);
    chk("R8 set again", {7'd0, chg_flag}, 8'h01);

    // R9: enable off, flag still set, irq low
    @(negedge clk); en_wr = 1; en_data = 0;
    @(negedge clk); en_wr = 0;
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    chk("R9 flag kept", {7'd0, chg_flag}, 8'h01);
    @(negedge clk); en_wr = 1; en_data = 1;
    @(negedge clk); en_wr = 0;
    chk("R9 irq enabled", {7'd0, irq}, 8'h01);

    // R10: a latch write leaves the snapshot at 0x0
    @(negedge clk); lat_wr = 1; wr_data = 8'h81;
    @(negedge clk); lat_wr = 0; flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    wait_edges(1);
    chk("R10 snapshot unchanged", {7'd0, chg_flag}, 8'h01);
    chk("R2 latch", pin_o, 8'h81);
    read_clear();
    wait_edges(3);
    chk("R11 after read", {7'd0, chg_flag}, 8'h00);

    // R2: direction write, upper pins outputs
    @(negedge clk); lat_wr = 1; wr_data = 8'h3C;
    @(negedge clk); lat_wr = 0; dir_wr = 1; wr_data = 8'h0F;
    @(negedge clk); dir_wr = 0;
    chk("R2 latch 3C", pin_o, 8'h3C);
    chk("R2 oe", pin_oe, 8'hF0);

    // R6: output pins ignored, counted again once inputs
    @(negedge clk); pin_i = 8'h71;
    wait_edges(4);
    chk("R6 outputs ignored", {7'd0, chg_flag}, 8'h00);
    chk("R3 outputs read", rd_data, 8'h71);
    @(negedge clk); dir_wr = 1; wr_data = 8'hFF;
    @(negedge clk); dir_wr = 0;
    wait_edges(1);
    chk("R6 inputs again", {7'd0, chg_flag}, 8'h01);
    chk("R2 oe off", pin_oe, 8'h00);

    finish_run();
  end
endmodule